// File: doc/BRIEF.md
# Thermal Trip Latch with Clock Shutdown

This block compares a digital junction temperature reading against a trip level and raises an active-low thermal-trip output once the reading reaches that level. The output may only be driven after power-good has been high for a fixed arming delay, given in clock cycles. Once the output fires, it holds regardless of later readings. While it is held, every clock-enable output is forced low, which stops the downstream logic. A power-off request asserts at the same moment, so that an external regulator can remove the core supply.

The only way to clear the trip is to drop power-good. Doing so releases the output at once and resets the arming delay. When power-good rises again, the delay runs from zero. If the reading is still at or above the level once the block is armed, the trip fires again.

Top module: `thermal_trip_latch`

## Requirements
- R1: While rst_ni is low, and after its release with power-good low, trip_no_o is 1, pwr_off_o is 0 and every bit of clk_en_o is 1.
- R2: A reading at or above the trip level is ignored until power-good has been sampled high on ARM_CYCLES consecutive rising edges. A reading that is hot throughout makes trip_no_o go low after rising edge ARM_CYCLES+1, and not earlier. A hot reading that is gone before arming completes never causes a trip.
- R3: The comparison is unsigned, with temp_i at or above trip_level_i meaning hot. With a level of 0xC0, a reading of 0xC0 trips, while 0xBF and 0x10 do not.
- R4: Once trip_no_o is low, it stays low while power-good stays high, whatever the reading does.
- R5: pwr_off_o is always the inverse of trip_no_o.
- R6: While the trip is active, all bits of clk_en_o are 0. Otherwise all bits are 1.
- R7: When power-good is low, trip_no_o is 1, pwr_off_o is 0 and clk_en_o is all ones, within the same cycle and with no clock edge needed. The latched trip is cleared at the next edge.
- R8: After the trip has been cleared by power-good, a return of power-good with the reading still hot trips again after rising edge ARM_CYCLES+1.
- R9: The arming count restarts from zero on every rise of power-good. A drop during the delay starts it over.
- R10: Once armed, the reading is compared on every edge. A reading that becomes hot trips the output after the first edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Power-good, synchronous to clk_i |
| temp_i | input | TEMP_W | Junction temperature reading, unsigned |
| trip_level_i | input | TEMP_W | Trip threshold, unsigned |
| trip_no_o | output | 1 | Thermal trip, active low |
| pwr_off_o | output | 1 | Request to remove the core supply |
| clk_en_o | output | N_DOM | Per-domain clock enables |

## Verification
The arming count and the trip latch are the internal state that matters here. An arming count that is wrong shows up as trip_no_o falling one or more cycles earlier or later than edge ARM_CYCLES+1 after power-good rises, so a bench that samples every cycle catches it on the first hot cycle. A latch that fails to hold or fails to clear shows up on the first cycle after the reading cools or after power-good drops. Because the reading uses a threshold with the top bit set, a signed comparison would trip on a cool reading.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned TT_TEMP_W = 8;
  localparam int unsigned TT_N_DOM  = 4;
  localparam int unsigned TT_ARM    = 1250; // 10 us at 125 MHz

  function automatic logic tt_hot(input logic [63:0] temp, input logic [63:0] lvl);
    return temp >= lvl;
  endfunction
endpackage

// File: rtl/tt_arm_timer.sv
module tt_arm_timer #(
  parameter int unsigned ARM_CYCLES = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(ARM_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(ARM_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!pwr_good_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      if (cnt_q == LAST) armed_q <= 1'b1;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/tt_trip_latch.sv
module tt_trip_latch #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              armed_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] lvl_i,
  output logic              trip_o
);
  import tt_pkg::*;

  logic trip_q;
  logic hot;

  assign hot = tt_hot(64'(temp_i), 64'(lvl_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          trip_q <= 1'b0;
    else if (!pwr_good_i) trip_q <= 1'b0;
    else if (armed_i && hot) trip_q <= 1'b1;
  end

  // power-good low masks the latch without waiting for an edge
  assign trip_o = trip_q & pwr_good_i;
endmodule

// File: rtl/tt_clk_gate.sv
module tt_clk_gate #(
  parameter int unsigned N_DOM = 4
) (
  input  logic             halt_i,
  output logic [N_DOM-1:0] en_o
);
  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign en_o[d] = ~halt_i;
  end
endmodule

// File: rtl/thermal_trip_latch.sv
module thermal_trip_latch #(
  parameter int unsigned TEMP_W     = tt_pkg::TT_TEMP_W,
  parameter int unsigned N_DOM      = tt_pkg::TT_N_DOM,
  parameter int unsigned ARM_CYCLES = tt_pkg::TT_ARM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] trip_level_i,
  output logic              trip_no_o,
  output logic              pwr_off_o,
  output logic [N_DOM-1:0]  clk_en_o
);
  logic armed;
  logic trip;

  tt_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .armed_o    (armed)
  );

  tt_trip_latch #(.TEMP_W(TEMP_W)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .armed_i    (armed),
    .temp_i     (temp_i),
    .lvl_i      (trip_level_i),
    .trip_o     (trip)
  );

  tt_clk_gate #(.N_DOM(N_DOM)) u_gate (
    .halt_i (trip),
    .en_o   (clk_en_o)
  );

  assign trip_no_o = ~trip;
  assign pwr_off_o = trip;
endmodule

// File: rtl/tt_trip_checker.sv
module tt_trip_checker #(
  parameter int unsigned TEMP_W     = 8,
  parameter int unsigned N_DOM      = 4,
  parameter int unsigned ARM_CYCLES = 1250
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_good_i,
  input logic [TEMP_W-1:0] temp_i,
  input logic [TEMP_W-1:0] trip_level_i,
  input logic              trip_no_o,
  input logic              pwr_off_o,
  input logic [N_DOM-1:0]  clk_en_o
);
  localparam int unsigned HW = $clog2(ARM_CYCLES + 2);
  localparam logic [HW-1:0] HMAX = HW'(ARM_CYCLES + 1);

  // consecutive power-good-high edges, saturating
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hi_cnt <= '0;
    else if (!pwr_good_i) hi_cnt <= '0;
    else if (hi_cnt != HMAX) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_early_trip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_no_o |-> hi_cnt == HMAX);

  assert_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trip_no_o) |-> $past(temp_i >= trip_level_i));

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trip_no_o && pwr_good_i) |=> (!trip_no_o || !pwr_good_i));

  assert_poff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_o == !trip_no_o);

  assert_halt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_no_o |-> clk_en_o == '0);

  assert_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_no_o |-> &clk_en_o);

  assert_pg_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> (trip_no_o && !pwr_off_o));
endmodule

bind thermal_trip_latch tt_trip_checker #(
  .TEMP_W(TEMP_W), .N_DOM(N_DOM), .ARM_CYCLES(ARM_CYCLES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_good_i   (pwr_good_i),
  .temp_i       (temp_i),
  .trip_level_i (trip_level_i),
  .trip_no_o    (trip_no_o),
  .pwr_off_o    (pwr_off_o),
  .clk_en_o     (clk_en_o)
);

// File: tb/sim_thermal_trip_latch.sv
`timescale 1ns/1ps
module sim_thermal_trip_latch;
  localparam int unsigned TW  = 8;
  localparam int unsigned ND  = 4;
  localparam int unsigned ARM = 20;
  localparam logic [TW-1:0] LVL  = 8'hC0;
  localparam logic [TW-1:0] HOT  = 8'hC8;
  localparam logic [TW-1:0] COOL = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0;
  logic [TW-1:0] temp = '0;
  logic [TW-1:0] lvl = LVL;
  logic trip_n, poff;
  logic [ND-1:0] en;

  always #4 clk = ~clk;

  thermal_trip_latch #(.TEMP_W(TW), .N_DOM(ND), .ARM_CYCLES(ARM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .temp_i(temp),
    .trip_level_i(lvl), .trip_no_o(trip_n), .pwr_off_o(poff), .clk_en_o(en)
  );

  typedef struct {
    bit    chk;
    bit    trip;
    string req;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;

  function automatic void compare(bit trip, string req);
    logic [ND-1:0] e_en;
    e_en = trip ? '0 : '1;
    n_chk++;
    if (trip_n !== !trip || poff !== trip || en !== e_en) begin
      n_bad++;
      $display("FAIL %s: trip_n=%b poff=%b en=%b expected trip_n=%b poff=%b en=%b",
               req, trip_n, poff, en, !trip, trip, e_en);
    end
  endfunction

  // monitor: checks state after each edge, 1 ns before the inputs move
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        if (it.chk) compare(it.trip, it.req);
      end
    end
  end

  // driver: set inputs at a falling edge, expect the result after the next rising edge
  task automatic cyc(input bit p, input logic [TW-1:0] t, input bit trip, input string req);
    item_t it;
    @(negedge clk);
    pg   = p;
    temp = t;
    it.chk = 1'b1; it.trip = trip; it.req = req;
    q.push_back(it);
  endtask

  task automatic drop(input string req);
    cyc(1'b0, HOT, 1'b0, req);
    #1 compare(1'b0, req); // no edge needed
    cyc(1'b0, HOT, 1'b0, req);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    temp = HOT;
    repeat (3) @(negedge clk);
    #1 compare(1'b0, "R1"); // in reset
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, HOT, 1'b0, "R1");

    // hot from the start: trip after edge ARM+1 only
    for (int i = 1; i <= ARM + 3; i++) cyc(1'b1, HOT, i > ARM, "R2 R5 R6");
    // cools: stays tripped
    for (int i = 0; i < 5; i++) cyc(1'b1, COOL, 1'b1, "R4");
    drop("R7");

    // returns still hot: re-trip
    for (int i = 1; i <= ARM + 2; i++) cyc(1'b1, HOT, i > ARM, "R8");
    drop("R7");

    // one below level, then equal after arming
    for (int i = 0; i < ARM + 5; i++) cyc(1'b1, 8'hBF, 1'b0, "R3");
    cyc(1'b1, LVL, 1'b1, "R3 R10");
    cyc(1'b1, 8'hBF, 1'b1, "R4");
    drop("R7");

    // glitch during arming restarts the count
    for (int i = 0; i < ARM - 5; i++) cyc(1'b1, HOT, 1'b0, "R9");
    cyc(1'b0, HOT, 1'b0, "R9");
    for (int i = 1; i <= ARM + 1; i++) cyc(1'b1, HOT, i > ARM, "R9");
    drop("R7");

    // hot only before arming, then cool with MSB-clear reading
    for (int i = 0; i < 10; i++) cyc(1'b1, HOT, 1'b0, "R2");
    for (int i = 0; i < ARM + 5; i++) cyc(1'b1, COOL, 1'b0, "R2 R3");
    cyc(1'b1, 8'hFF, 1'b1, "R10");

    // drain queue
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule